// File: doc/BRIEF.md
# Sign-Data LMS Channel Gain Equalizer

This block matches the gains of the channels of an interleaved converter. Channel 0 is the reference. Every other channel gets a weight that scales its samples so that its gain equals the reference gain. The block sits after offset removal. Its inputs are the offset-corrected, filtered sample streams, one per channel, all delivered together under a shared valid strobe.

During calibration the same constant level is applied to every channel. Each non-reference channel first multiplies its sample by its current weight. It then takes the error between the reference sample and that weighted sample, and adds the error to its weight when its own sample is non-negative, or subtracts it when the sample is negative. The update is therefore a sign-data LMS step with unit step size. The error is moved from sample LSBs to weight LSBs by rounding upward.

A channel stops adapting once its weight has moved by less than a programmable threshold across a lag of three updates. Calibration ends when every non-reference channel has stopped, or when a maximum update count expires; the timeout case is flagged. Outside calibration the block multiplies each channel by its held weight and forwards all channels.

Top module: `gain_equalizer`

## Requirements
- R1: Outside calibration, a sample beat presented with `smp_valid` high appears on the outputs one clock later with `out_valid` high, and the reference channel (slot 0) passes through unchanged. `out_valid` is low during calibration and in any cycle after one without a valid beat.
- R2: In normal mode, output slot c (c ≥ 1) equals floor(y_c · w_c / 2^18). Here y_c is the signed 25-bit two's-complement sample in slot c (bits [25c+24:25c] of the bus), and w_c is that channel's unsigned 19-bit weight with 18 fraction bits.
- R3: At reset and at every `cal_start` pulse, all weights become 1.0 (0x40000) and all converged flags clear. A `cal_start` pulse during calibration restarts it from that state.
- R4: During calibration, each valid beat updates each unconverged channel. With e = y_0 − floor(y_c·w_c/2^18), the step is d = ceil(e / 64). The new weight is w + d when y_c ≥ 0 (a zero sample counts as positive) and w − d when y_c < 0.
- R5: A weight update that would go below 0 holds at 0, and one that would exceed 0x7FFFF holds at 0x7FFFF.
- R6: From a channel's third update on, if |new weight − weight three updates earlier| < `cal_thresh`, the channel's converged flag sets and its weight freezes. Earlier updates never set the flag.
- R7: When all non-reference channels have converged, `cal_done` rises and `cal_busy` falls one clock later. With a valid beat every cycle after `cal_start`, `cal_done` is first seen n+1 clocks after the `cal_start` edge, where n is the number of updates. Weights then hold.
- R8: If MAX_UPD (default 64) updates have been made without all channels converging, the block leaves calibration with `cal_done` and `cal_timeout` both high, on the clock after the last update.
- R9: Weighted outputs saturate to the signed 25-bit range [−2^24, 2^24−1].
- R10: During calibration, cycles with `smp_valid` low make no update and do not count toward MAX_UPD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cal_start | input | 1 | One-cycle pulse that starts or restarts calibration |
| cal_thresh | input | 19 | Convergence threshold in weight LSBs |
| smp_valid | input | 1 | Sample beat valid for all channels |
| smp_in | input | 100 | Four signed 25-bit samples, slot c at [25c+24:25c] |
| out_valid | output | 1 | Output beat valid (normal mode only) |
| smp_out | output | 100 | Four signed 25-bit weighted samples, same slot layout |
| ch_converged | output | 3 | Bit k is the converged flag of channel k+1 |
| cal_busy | output | 1 | Calibration in progress |
| cal_done | output | 1 | Last calibration finished |
| cal_timeout | output | 1 | Last calibration ended by the update limit |

## Verification
The bench drives gains slightly above and below the reference with positive and with negative levels. A design with the sign handling reversed would diverge instead of halving its error each update. A channel with a zero sample must ramp its weight up to the upper limit, and a channel of opposite polarity must drive its weight down to zero. Wrong clamping would wrap these weights and never converge, and a design without output saturation would wrap large weighted samples.

A zero threshold forces the timeout path, and an exact cycle count for the done flag catches an off-by-one in the lag comparison or in the update limit. Random gaps in the valid strobe and a restart in mid-calibration expose designs that update on idle cycles or fail to reload the weights to 1.0.

// File: rtl/geq_pkg.sv
package geq_pkg;

    parameter int GEQ_NUM_CH   = 4;
    parameter int GEQ_SAMPLE_W = 25;
    parameter int GEQ_WEIGHT_W = 19;
    parameter int GEQ_FRAC_W   = 18;
    parameter int GEQ_LAG      = 3;
    parameter int GEQ_MAX_UPD  = 64;

    typedef enum logic {
        MODE_NORMAL = 1'b0,
        MODE_CAL    = 1'b1
    } geq_mode_e;

endpackage

// File: rtl/geq_weight_mul.sv
module geq_weight_mul #(
    parameter int SAMPLE_W = geq_pkg::GEQ_SAMPLE_W,
    parameter int WEIGHT_W = geq_pkg::GEQ_WEIGHT_W,
    parameter int FRAC_W   = geq_pkg::GEQ_FRAC_W
) (
    input  logic [SAMPLE_W-1:0] smp,
    input  logic [WEIGHT_W-1:0] weight,
    output logic [SAMPLE_W-1:0] result
);
    localparam int PROD_W = SAMPLE_W + WEIGHT_W + 1;
    localparam logic signed [PROD_W-1:0] SMAX =
        {{(PROD_W-SAMPLE_W+1){1'b0}}, {(SAMPLE_W-1){1'b1}}};
    localparam logic signed [PROD_W-1:0] SMIN =
        {{(PROD_W-SAMPLE_W+1){1'b1}}, {(SAMPLE_W-1){1'b0}}};

    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] scaled;

    always_comb begin
        prod   = $signed(smp) * $signed({1'b0, weight});
        scaled = prod >>> FRAC_W;
        if (scaled > SMAX) begin
            result = SMAX[SAMPLE_W-1:0];
        end else if (scaled < SMIN) begin
            result = SMIN[SAMPLE_W-1:0];
        end else begin
            result = scaled[SAMPLE_W-1:0];
        end
    end

endmodule

// File: rtl/geq_lane.sv
module geq_lane #(
    parameter int SAMPLE_W = geq_pkg::GEQ_SAMPLE_W,
    parameter int WEIGHT_W = geq_pkg::GEQ_WEIGHT_W,
    parameter int FRAC_W   = geq_pkg::GEQ_FRAC_W,
    parameter int LAG      = geq_pkg::GEQ_LAG
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                restart,
    input  logic                step,
    input  logic [SAMPLE_W-1:0] ref_smp,
    input  logic [SAMPLE_W-1:0] ch_smp,
    input  logic [WEIGHT_W-1:0] thr,
    output logic [SAMPLE_W-1:0] weighted,
    output logic                converged
);
    localparam int SHIFT = SAMPLE_W - 1 - FRAC_W;
    localparam int ACC_W = WEIGHT_W + SAMPLE_W + 2;
    localparam int CNT_W = $clog2(LAG + 1);
    localparam logic [WEIGHT_W-1:0] W_ONE = WEIGHT_W'(1) << FRAC_W;
    localparam logic signed [ACC_W-1:0] RND = ACC_W'((2 ** SHIFT) - 1);
    localparam logic signed [ACC_W-1:0] WLIM =
        {{(ACC_W-WEIGHT_W){1'b0}}, {WEIGHT_W{1'b1}}};

    typedef struct packed {
        logic [LAG-1:0][WEIGHT_W-1:0] win;
        logic [CNT_W-1:0]             nupd;
        logic                         conv;
    } lane_t;

    lane_t q, d;

    logic signed [ACC_W-1:0] ref_x, wsm_x, w_x, err, delta, cand;
    logic [WEIGHT_W-1:0]     new_w, gap, oldest;

    geq_weight_mul #(
        .SAMPLE_W (SAMPLE_W),
        .WEIGHT_W (WEIGHT_W),
        .FRAC_W   (FRAC_W)
    ) u_mul (
        .smp    (ch_smp),
        .weight (q.win[0]),
        .result (weighted)
    );

    always_comb begin
        ref_x = {{(ACC_W-SAMPLE_W){ref_smp[SAMPLE_W-1]}}, ref_smp};
        wsm_x = {{(ACC_W-SAMPLE_W){weighted[SAMPLE_W-1]}}, weighted};
        w_x   = {{(ACC_W-WEIGHT_W){1'b0}}, q.win[0]};
        err   = ref_x - wsm_x;
        delta = (err + RND) >>> SHIFT;
        cand  = ch_smp[SAMPLE_W-1] ? (w_x - delta) : (w_x + delta);
        if (cand[ACC_W-1]) begin
            new_w = '0;
        end else if (cand > WLIM) begin
            new_w = '1;
        end else begin
            new_w = cand[WEIGHT_W-1:0];
        end
        oldest = q.win[LAG-1];
        gap    = (new_w >= oldest) ? (new_w - oldest) : (oldest - new_w);

        d = q;
        if (restart) begin
            for (int k = 0; k < LAG; k++) begin
                d.win[k] = W_ONE;
            end
            d.nupd = '0;
            d.conv = 1'b0;
        end else if (step && !q.conv) begin
            for (int k = LAG - 1; k > 0; k--) begin
                d.win[k] = q.win[k-1];
            end
            d.win[0] = new_w;
            if (q.nupd < CNT_W'(LAG)) begin
                d.nupd = q.nupd + 1'b1;
            end
            if ((q.nupd >= CNT_W'(LAG - 1)) && (gap < thr)) begin
                d.conv = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < LAG; k++) begin
                q.win[k] <= W_ONE;
            end
            q.nupd <= '0;
            q.conv <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign converged = q.conv;

    assert_restart_loads_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (q.win[0] == W_ONE) && !converged);

    assert_frozen_after_converge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (converged && !restart) |=> $stable(q.win[0]));

    assert_converge_needs_lag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(converged) |-> (q.nupd >= CNT_W'(LAG)));

    assert_idle_holds_weight_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !restart) |=> $stable(q.win[0]));

endmodule

// File: rtl/gain_equalizer.sv
module gain_equalizer
    import geq_pkg::*;
#(
    parameter int NUM_CH   = GEQ_NUM_CH,
    parameter int SAMPLE_W = GEQ_SAMPLE_W,
    parameter int WEIGHT_W = GEQ_WEIGHT_W,
    parameter int FRAC_W   = GEQ_FRAC_W,
    parameter int LAG      = GEQ_LAG,
    parameter int MAX_UPD  = GEQ_MAX_UPD
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cal_start,
    input  logic [WEIGHT_W-1:0]          cal_thresh,
    input  logic                         smp_valid,
    input  logic [NUM_CH*SAMPLE_W-1:0]   smp_in,
    output logic                         out_valid,
    output logic [NUM_CH*SAMPLE_W-1:0]   smp_out,
    output logic [NUM_CH-2:0]            ch_converged,
    output logic                         cal_busy,
    output logic                         cal_done,
    output logic                         cal_timeout
);
    localparam int UPD_W = $clog2(MAX_UPD + 1);

    typedef struct packed {
        geq_mode_e                        mode;
        logic                             done;
        logic                             tout;
        logic [UPD_W-1:0]                 cnt;
        logic                             ovalid;
        logic [NUM_CH-1:0][SAMPLE_W-1:0]  out;
    } top_t;

    top_t q, d;

    logic [NUM_CH-1:0][SAMPLE_W-1:0] weighted;
    logic [NUM_CH-2:0]               conv;
    logic                            all_conv;
    logic                            step;

    assign weighted[0] = smp_in[SAMPLE_W-1:0];
    assign all_conv    = &conv;
    assign step        = (q.mode == MODE_CAL) && smp_valid && !cal_start
                         && (q.cnt != UPD_W'(MAX_UPD)) && !all_conv;

    for (genvar c = 1; c < NUM_CH; c++) begin : g_lane
        geq_lane #(
            .SAMPLE_W (SAMPLE_W),
            .WEIGHT_W (WEIGHT_W),
            .FRAC_W   (FRAC_W),
            .LAG      (LAG)
        ) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .restart   (cal_start),
            .step      (step),
            .ref_smp   (smp_in[SAMPLE_W-1:0]),
            .ch_smp    (smp_in[c*SAMPLE_W +: SAMPLE_W]),
            .thr       (cal_thresh),
            .weighted  (weighted[c]),
            .converged (conv[c-1])
        );
    end

    always_comb begin
        d = q;
        d.ovalid = smp_valid && (q.mode == MODE_NORMAL) && !cal_start;
        if (d.ovalid) begin
            d.out = weighted;
        end
        if (cal_start) begin
            d.mode = MODE_CAL;
            d.done = 1'b0;
            d.tout = 1'b0;
            d.cnt  = '0;
        end else if (q.mode == MODE_CAL) begin
            if (all_conv) begin
                d.mode = MODE_NORMAL;
                d.done = 1'b1;
            end else if (q.cnt == UPD_W'(MAX_UPD)) begin
                d.mode = MODE_NORMAL;
                d.done = 1'b1;
                d.tout = 1'b1;
            end else if (step) begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.mode   <= MODE_NORMAL;
            q.done   <= 1'b0;
            q.tout   <= 1'b0;
            q.cnt    <= '0;
            q.ovalid <= 1'b0;
            q.out    <= '0;
        end else begin
            q <= d;
        end
    end

    assign out_valid    = q.ovalid;
    assign smp_out      = q.out;
    assign ch_converged = conv;
    assign cal_busy     = (q.mode == MODE_CAL);
    assign cal_done     = q.done;
    assign cal_timeout  = q.tout;

    assert_no_output_in_cal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cal_busy |-> !out_valid);

    assert_done_not_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(cal_done && cal_busy));

    assert_done_means_converged_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cal_done) && !cal_timeout) |-> (&ch_converged));

    assert_timeout_implies_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cal_timeout |-> cal_done);

    assert_update_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= UPD_W'(MAX_UPD));

endmodule

// File: tb/gain_equalizer_bench.sv
module gain_equalizer_bench;
    localparam int NCH  = 4;
    localparam int SW   = 25;
    localparam int WW   = 19;
    localparam int FW   = 18;
    localparam int LAG  = 3;
    localparam int MAXU = 64;
    localparam longint ONE  = longint'(1) << FW;
    localparam longint WTOP = (longint'(1) << WW) - 1;
    localparam longint SHI  = (longint'(1) << (SW - 1)) - 1;
    localparam longint SLO  = -(longint'(1) << (SW - 1));

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                cal_start = 1'b0;
    logic [WW-1:0]       cal_thresh = '0;
    logic                smp_valid = 1'b0;
    logic [NCH*SW-1:0]   smp_in = '0;
    logic                out_valid;
    logic [NCH*SW-1:0]   smp_out;
    logic [NCH-2:0]      ch_converged;
    logic                cal_busy, cal_done, cal_timeout;

    int nchk = 0;
    int nerr = 0;

    longint ys [NCH];
    longint mw [NCH];
    bit     mconv [NCH];
    int     mn;
    bit     mtout;

    always #2 clk = ~clk;

    gain_equalizer u_gain_equalizer (
        .clk          (clk),
        .rst_n        (rst_n),
        .cal_start    (cal_start),
        .cal_thresh   (cal_thresh),
        .smp_valid    (smp_valid),
        .smp_in       (smp_in),
        .out_valid    (out_valid),
        .smp_out      (smp_out),
        .ch_converged (ch_converged),
        .cal_busy     (cal_busy),
        .cal_done     (cal_done),
        .cal_timeout  (cal_timeout)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic longint wapply(input longint y, input longint w);
        longint p;
        p = (y * w) >>> FW;
        if (p > SHI) p = SHI;
        if (p < SLO) p = SLO;
        return p;
    endfunction

    function automatic longint rnd_smp();
        logic [SW-1:0] r;
        r = SW'($urandom);
        return longint'($signed(r));
    endfunction

    function automatic longint slot(input int c);
        logic [SW-1:0] r;
        r = smp_out[c*SW +: SW];
        return longint'($signed(r));
    endfunction

    task automatic drive_samples();
        for (int c = 0; c < NCH; c++) begin
            smp_in[c*SW +: SW] = ys[c][SW-1:0];
        end
    endtask

    // Requirement model of one calibration run (R4, R5, R6, R8)
    task automatic model_cal(input longint thr);
        longint h [NCH][LAG];
        longint z, e, dl, nw;
        bit all;
        for (int c = 0; c < NCH; c++) begin
            mw[c] = ONE;
            mconv[c] = (c == 0);
            for (int k = 0; k < LAG; k++) h[c][k] = ONE;
        end
        mn = 0;
        all = 1'b0;
        while (mn < MAXU && !all) begin
            mn++;
            for (int c = 1; c < NCH; c++) begin
                if (!mconv[c]) begin
                    z  = wapply(ys[c], mw[c]);
                    e  = ys[0] - z;
                    dl = (e + 63) >>> 6;
                    nw = (ys[c] < 0) ? mw[c] - dl : mw[c] + dl;
                    if (nw < 0) nw = 0;
                    if (nw > WTOP) nw = WTOP;
                    if (mn >= LAG) begin
                        longint df;
                        df = nw - h[c][LAG-1];
                        if (df < 0) df = -df;
                        if (df < thr) mconv[c] = 1'b1;
                    end
                    for (int k = LAG - 1; k > 0; k--) h[c][k] = h[c][k-1];
                    h[c][0] = nw;
                    mw[c] = nw;
                end
            end
            all = 1'b1;
            for (int c = 1; c < NCH; c++) if (!mconv[c]) all = 1'b0;
        end
        mtout = !all;
    endtask

    task automatic run_cal(input longint thr, input bit gaps, output int cycles);
        @(negedge clk);
        cal_thresh = WW'(thr);
        cal_start = 1'b1;
        smp_valid = 1'b0;
        drive_samples();
        @(negedge clk);
        cal_start = 1'b0;
        smp_valid = gaps ? 1'($urandom % 2) : 1'b1;
        cycles = 0;
        while (cycles < 2000) begin
            @(negedge clk);
            cycles++;
            if (out_valid) check(1'b0, "R1", "out_valid during calibration", 1, 0);
            if (cal_done) break;
            smp_valid = gaps ? 1'($urandom % 2) : 1'b1;
        end
        smp_valid = 1'b0;
    endtask

    task automatic check_flags(input string req);
        for (int c = 1; c < NCH; c++) begin
            check(ch_converged[c-1] == mconv[c], req, $sformatf("converged ch%0d", c),
                  ch_converged[c-1], mconv[c]);
        end
        check(cal_timeout == mtout, "R8", "timeout flag", cal_timeout, mtout);
        check(cal_done && !cal_busy, "R7", "done and idle", {cal_done, cal_busy}, 2);
    endtask

    // normal mode: R1, R2, R9
    task automatic check_normal(input int n, input bit directed, input string req);
        for (int s = 0; s < n; s++) begin
            if (!directed) for (int c = 0; c < NCH; c++) ys[c] = rnd_smp();
            drive_samples();
            smp_valid = 1'b1;
            @(negedge clk);
            check(out_valid, "R1", "out_valid after beat", out_valid, 1);
            check(slot(0) == ys[0], "R1", "reference passthrough", slot(0), ys[0]);
            for (int c = 1; c < NCH; c++) begin
                check(slot(c) == wapply(ys[c], mw[c]), req, $sformatf("weighted ch%0d", c),
                      slot(c), wapply(ys[c], mw[c]));
            end
        end
        smp_valid = 1'b0;
        @(negedge clk);
        check(!out_valid, "R1", "out_valid without beat", out_valid, 0);
    endtask

    task automatic near_unity_gains(input longint lvl);
        ys[0] = lvl;
        for (int c = 1; c < NCH; c++) begin
            ys[c] = lvl + ((lvl < 0) ? -1 : 1) *
                    (longint'($urandom_range(0, 1 << 19)) - (longint'(1) << 18));
        end
    endtask

    initial begin
        int cyc;
        void'($urandom(32'd7351));
        for (int c = 0; c < NCH; c++) mw[c] = ONE;

        repeat (3) @(negedge clk);
        check(!out_valid && !cal_busy && !cal_done && !cal_timeout && ch_converged == '0,
              "R3", "reset state", {out_valid, cal_busy, cal_done, cal_timeout}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // weights are 1.0 after reset
        check_normal(6, 1'b0, "R3");

        // A: positive level, continuous beats
        near_unity_gains(longint'(1) << 23);
        model_cal(4);
        run_cal(4, 1'b0, cyc);
        check(cyc == mn + 1, "R7", "cycles to done", cyc, mn + 1);
        check_flags("R6");
        check_normal(8, 1'b0, "R4");

        // B: gaps in the valid strobe
        near_unity_gains(longint'(3) << 21);
        model_cal(3);
        run_cal(3, 1'b1, cyc);
        check_flags("R10");
        check_normal(6, 1'b0, "R10");

        // C: negative level flips the update direction
        near_unity_gains(-(longint'(1) << 23));
        model_cal(4);
        run_cal(4, 1'b0, cyc);
        check(cyc == mn + 1, "R4", "cycles to done negative", cyc, mn + 1);
        check_flags("R4");
        check_normal(6, 1'b0, "R4");

        // D: zero sample, tiny gain, opposite polarity -> weight limits
        ys[0] = longint'(1) << 23;
        ys[1] = 0;
        ys[2] = longint'(1) << 20;
        ys[3] = -(longint'(1) << 23);
        model_cal(1);
        run_cal(1, 1'b0, cyc);
        check(cyc == mn + 1, "R5", "cycles to done limits", cyc, mn + 1);
        check_flags("R5");
        check(mw[1] == WTOP && mw[2] == WTOP && mw[3] == 0, "R5", "model limits",
              mw[3], 0);
        for (int c = 0; c < NCH; c++) ys[c] = SHI;
        check_normal(1, 1'b1, "R9");
        for (int c = 0; c < NCH; c++) ys[c] = SLO;
        check_normal(1, 1'b1, "R9");
        check_normal(4, 1'b0, "R5");

        // E: zero threshold never converges -> timeout
        near_unity_gains(longint'(1) << 23);
        model_cal(0);
        run_cal(0, 1'b0, cyc);
        check(cyc == MAXU + 1, "R8", "cycles to timeout", cyc, MAXU + 1);
        check_flags("R8");
        check_normal(4, 1'b0, "R8");

        // F: restart in the middle of a calibration
        near_unity_gains(longint'(1) << 22);
        @(negedge clk);
        cal_thresh = WW'(2);
        cal_start = 1'b1;
        drive_samples();
        @(negedge clk);
        cal_start = 1'b0;
        smp_valid = 1'b1;
        repeat (5) @(negedge clk);
        near_unity_gains(longint'(5) << 21);
        model_cal(2);
        run_cal(2, 1'b0, cyc);
        check(cyc == mn + 1, "R3", "cycles after restart", cyc, mn + 1);
        check_flags("R3");
        check_normal(6, 1'b0, "R3");

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        #(4 * 150000);
        check(1'b0, "WATCHDOG", "run did not end", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule